// File: doc/BRIEF.md
# Reset Supervisor with Cause Logging

The block merges three reset requests into a single active-low system reset for the processor core and its peripherals. The requests are an active-low external reset pin, a one-cycle expiry pulse from a watchdog, and a level from a power-fail (brown-out) comparator. The pin and the power-fail level are asynchronous, so each passes through a two-flop synchroniser first. The pin must also stay low for a minimum run of clocks before it counts, which rejects noise and short glitches. The system reset asserts as soon as any request is seen, and a power-fail level asserts it at once without waiting for a clock. It deasserts on a clock edge only after a fixed number of quiet cycles.

While the system reset is low, the block overrides every pad output and output enable with a protective pattern. General ports drive high. Port 0 and the flash data bus float. The flash write-protect is held low so that no spurious write can reach the memory. The flash chip-enable is held high. Once the reset is released the processor fetches from address 0000h, and the pads follow the processor's own values again.

A 3-bit cause register records which request produced the most recent reset. It is kept through the system reset it describes, so firmware can read it after boot. Firmware clears it one bit at a time by writing ones.

Top module: `rst_supervisor`

## Requirements
- R1: The external pin is active low. It is synchronised by two flops and counts as a reset request only after its synchronised value has been low for at least 4 consecutive clocks. A low pulse of 3 clocks or less changes neither `sys_rst_n_o` nor `cause_o`. A pulse of exactly 4 clocks triggers a reset.
- R2: A one-cycle watchdog pulse alone, or a power-fail level alone, pulls `sys_rst_n_o` low. The watchdog pulse takes effect at the clock edge that samples it. The power-fail level takes effect immediately, with no clock edge needed.
- R3: `sys_rst_n_o` rises on a clock edge, exactly 16 edges after the last edge at which any request was still active.
- R4: Cause bits: bit 0 means power-fail, bit 1 means external pin, bit 2 means watchdog. When a request becomes active and no request was active in the previous cycle, `cause_o` becomes exactly the bit or bits of the requests that just became active.
- R5: Requests that become active in the same cycle all have their bits set. A watchdog or pin request that becomes active while another request is still active adds its bit to the bits already set.
- R6: A power-fail request that becomes active clears the external and watchdog bits, even while another request is still active. Only its own bit remains, together with any request that became active in that same cycle.
- R7: `cause_o` keeps its value through the system reset and is cleared only by `arst_n` or by firmware. When `clr_we_i` is high, each bit set in `clr_data_i` clears the matching cause bit, and a bit that is 0 in `clr_data_i` leaves its cause bit unchanged. A cause bit that is being set in the same cycle stays set.
- R8: While `sys_rst_n_o` is low, the pad outputs are forced as follows. Ports 1 to 5 have output data and enable all ones. Port 0 and the flash data bus have output enable all zeros and output data zero. `fl_wp_o` is 0 and `fl_ce_o` is 1. While `sys_rst_n_o` is high, every pad output equals its matching input.
- R9: While `arst_n` is low, `sys_rst_n_o` is low and `cause_o` is 000. After `arst_n` rises, `sys_rst_n_o` rises at the 16th clock edge, provided no request is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Power-on reset of the supervisor itself, active low |
| ext_rst_n_i | input | 1 | External reset pin, asynchronous, active low |
| wdt_expire_i | input | 1 | Watchdog expiry pulse, synchronous |
| brownout_i | input | 1 | Power-fail detect level, asynchronous, active high |
| clr_we_i | input | 1 | Cause clear strobe |
| clr_data_i | input | 3 | Write-one-to-clear mask for the cause bits |
| cause_o | output | 3 | Cause bits: [0] power-fail, [1] pin, [2] watchdog |
| sys_rst_n_o | output | 1 | System reset to core and peripherals, active low |
| port_do_i | input | 48 | Processor port output data, port p in bits [8p+7:8p] |
| port_oe_i | input | 48 | Processor port output enables |
| port_do_o | output | 48 | Port output data to the pads |
| port_oe_o | output | 48 | Port output enables to the pads |
| fl_do_i | input | 8 | Processor flash data output |
| fl_oe_i | input | 8 | Processor flash data output enables |
| fl_wp_i | input | 1 | Processor flash write-protect level |
| fl_ce_i | input | 1 | Processor flash chip-enable level |
| fl_do_o | output | 8 | Flash data to the pads |
| fl_oe_o | output | 8 | Flash data output enables to the pads |
| fl_wp_o | output | 1 | Flash write-protect to the pad |
| fl_ce_o | output | 1 | Flash chip-enable to the pad |

## Verification
The assertions assume the watchdog drives a clean pulse of one cycle in the supervisor's clock domain. They also assume the external pin and the power-fail level change away from the clock edge. If the watchdog line were held high, a power-fail request arriving a cycle later could take over the cause register while the watchdog line was still high. The directed stimulus therefore raises the watchdog line for exactly one cycle. It changes every asynchronous input on the falling clock edge, and it waits for the system reset to rise before starting each new scenario.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int CAUSE_W = 3;
  localparam int PF_BIT  = 0;
  localparam int EXT_BIT = 1;
  localparam int WDT_BIT = 2;
  typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int   WIDTH   = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= {WIDTH{RST_VAL}};
      s2_q <= {WIDTH{RST_VAL}};
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rsc_pin_filter.sv
module rsc_pin_filter #(
  parameter int MIN_LOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic req_o
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] TOP = CW'(MIN_LOW);

  logic [CW-1:0] run_q, run_d;
  logic          run_en;

  always_comb begin
    run_en = 1'b0;
    run_d  = run_q;
    if (pin_n_i) begin
      run_en = (run_q != '0);
      run_d  = '0;
    end else if (run_q != TOP) begin
      run_en = 1'b1;
      run_d  = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign req_o = (run_q == TOP);
endmodule

// File: rtl/rsc_stretch.sv
module rsc_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic clr_n,
  input  logic req_i,
  output logic rel_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rel_q, rel_d;
  logic          en;

  always_comb begin
    en    = 1'b0;
    cnt_d = cnt_q;
    rel_d = rel_q;
    if (req_i) begin
      en    = 1'b1;
      cnt_d = '0;
      rel_d = 1'b0;
    end else if (!rel_q) begin
      en    = 1'b1;
      cnt_d = cnt_q + 1'b1;
      rel_d = (cnt_q == LAST);
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end

  assign rel_o = rel_q;
endmodule

// File: rtl/rsc_cause_log.sv
module rsc_cause_log
  import rsc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cause_t src_act_i,
  input  logic   clr_we_i,
  input  cause_t clr_mask_i,
  output cause_t cause_o
);
  cause_t act_q, flags_q, flags_d, rise;
  logic   fresh, en;

  assign rise  = src_act_i & ~act_q;
  assign fresh = (|rise) && !(|act_q);

  always_comb begin
    flags_d = flags_q;
    if (fresh || rise[PF_BIT]) flags_d = rise;
    else                       flags_d = flags_q | rise;
    if (clr_we_i)              flags_d = flags_d & ~(clr_mask_i & ~rise);
    en = (flags_d != flags_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= src_act_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flags_q <= '0;
    else if (en) flags_q <= flags_d;
  end

  assign cause_o = flags_q;
endmodule

// File: rtl/rsc_pad_guard.sv
module rsc_pad_guard #(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 8,
  parameter int FLASH_W   = 8
) (
  input  logic                        force_i,
  input  logic [NUM_PORTS*PORT_W-1:0] port_do_i,
  input  logic [NUM_PORTS*PORT_W-1:0] port_oe_i,
  output logic [NUM_PORTS*PORT_W-1:0] port_do_o,
  output logic [NUM_PORTS*PORT_W-1:0] port_oe_o,
  input  logic [FLASH_W-1:0]          fl_do_i,
  input  logic [FLASH_W-1:0]          fl_oe_i,
  input  logic                        fl_wp_i,
  input  logic                        fl_ce_i,
  output logic [FLASH_W-1:0]          fl_do_o,
  output logic [FLASH_W-1:0]          fl_oe_o,
  output logic                        fl_wp_o,
  output logic                        fl_ce_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    if (p == 0) begin : g_float
      assign port_do_o[p*PORT_W +: PORT_W] = force_i ? '0 : port_do_i[p*PORT_W +: PORT_W];
      assign port_oe_o[p*PORT_W +: PORT_W] = force_i ? '0 : port_oe_i[p*PORT_W +: PORT_W];
    end else begin : g_high
      assign port_do_o[p*PORT_W +: PORT_W] = force_i ? '1 : port_do_i[p*PORT_W +: PORT_W];
      assign port_oe_o[p*PORT_W +: PORT_W] = force_i ? '1 : port_oe_i[p*PORT_W +: PORT_W];
    end
  end

  assign fl_do_o = force_i ? '0 : fl_do_i;
  assign fl_oe_o = force_i ? '0 : fl_oe_i;
  assign fl_wp_o = force_i ? 1'b0 : fl_wp_i;
  assign fl_ce_o = force_i ? 1'b1 : fl_ce_i;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsc_pkg::*;
#(
  parameter int NUM_PORTS   = 6,
  parameter int PORT_W      = 8,
  parameter int FLASH_W     = 8,
  parameter int EXT_MIN_LOW = 4,
  parameter int HOLD_CYC    = 16
) (
  input  logic                        clk,
  input  logic                        arst_n,
  input  logic                        ext_rst_n_i,
  input  logic                        wdt_expire_i,
  input  logic                        brownout_i,
  input  logic                        clr_we_i,
  input  logic [CAUSE_W-1:0]          clr_data_i,
  output logic [CAUSE_W-1:0]          cause_o,
  output logic                        sys_rst_n_o,
  input  logic [NUM_PORTS*PORT_W-1:0] port_do_i,
  input  logic [NUM_PORTS*PORT_W-1:0] port_oe_i,
  output logic [NUM_PORTS*PORT_W-1:0] port_do_o,
  output logic [NUM_PORTS*PORT_W-1:0] port_oe_o,
  input  logic [FLASH_W-1:0]          fl_do_i,
  input  logic [FLASH_W-1:0]          fl_oe_i,
  input  logic                        fl_wp_i,
  input  logic                        fl_ce_i,
  output logic [FLASH_W-1:0]          fl_do_o,
  output logic [FLASH_W-1:0]          fl_oe_o,
  output logic                        fl_wp_o,
  output logic                        fl_ce_o
);
  logic   ext_sync_n, pf_sync, ext_req, any_req, hold_clr_n, rel;
  cause_t src_act;

  rsc_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_ext_sync (
    .clk(clk), .rst_n(arst_n), .d_i(ext_rst_n_i), .q_o(ext_sync_n));

  rsc_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_pf_sync (
    .clk(clk), .rst_n(arst_n), .d_i(brownout_i), .q_o(pf_sync));

  rsc_pin_filter #(.MIN_LOW(EXT_MIN_LOW)) u_filter (
    .clk(clk), .rst_n(arst_n), .pin_n_i(ext_sync_n), .req_o(ext_req));

  always_comb begin
    src_act          = '0;
    src_act[PF_BIT]  = pf_sync;
    src_act[EXT_BIT] = ext_req;
    src_act[WDT_BIT] = wdt_expire_i;
  end

  assign any_req    = |src_act;
  assign hold_clr_n = arst_n & ~brownout_i;

  rsc_stretch #(.HOLD(HOLD_CYC)) u_stretch (
    .clk(clk), .clr_n(hold_clr_n), .req_i(any_req), .rel_o(rel));

  rsc_cause_log u_cause (
    .clk(clk), .rst_n(arst_n), .src_act_i(src_act),
    .clr_we_i(clr_we_i), .clr_mask_i(clr_data_i), .cause_o(cause_o));

  rsc_pad_guard #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .FLASH_W(FLASH_W)) u_pads (
    .force_i(~rel),
    .port_do_i(port_do_i), .port_oe_i(port_oe_i),
    .port_do_o(port_do_o), .port_oe_o(port_oe_o),
    .fl_do_i(fl_do_i), .fl_oe_i(fl_oe_i), .fl_wp_i(fl_wp_i), .fl_ce_i(fl_ce_i),
    .fl_do_o(fl_do_o), .fl_oe_o(fl_oe_o), .fl_wp_o(fl_wp_o), .fl_ce_o(fl_ce_o));

  assign sys_rst_n_o = rel;
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
  parameter int HOLD_CYC = 16,
  parameter int FLASH_W  = 8
) (
  input logic               clk,
  input logic               arst_n,
  input logic               wdt_expire_i,
  input logic               brownout_i,
  input logic               sys_rst_n_o,
  input logic [2:0]         cause_o,
  input logic [FLASH_W-1:0] fl_oe_o,
  input logic               fl_wp_o,
  input logic               fl_ce_o
);
  logic [31:0] low_run_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)          low_run_q <= '0;
    else if (sys_rst_n_o) low_run_q <= '0;
    else                  low_run_q <= low_run_q + 1;
  end

  assert_pf_async_R2: assert property (@(posedge clk) disable iff (!arst_n)
    brownout_i |-> !sys_rst_n_o);

  assert_wdt_resets_R2: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_expire_i |=> !sys_rst_n_o);

  assert_hold_len_R3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sys_rst_n_o) |-> (low_run_q >= 32'(HOLD_CYC)));

  assert_release_quiet_R3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sys_rst_n_o) |-> (!$past(wdt_expire_i) && !brownout_i));

  assert_wdt_logged_R4: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_expire_i |=> (cause_o[2] || cause_o[0]));

  assert_pads_safe_R8: assert property (@(posedge clk) disable iff (!arst_n)
    !sys_rst_n_o |-> (!fl_wp_o && fl_ce_o && (fl_oe_o == '0)));
endmodule

bind rst_supervisor rst_supervisor_chk #(.HOLD_CYC(HOLD_CYC), .FLASH_W(FLASH_W)) u_chk (
  .clk(clk), .arst_n(arst_n), .wdt_expire_i(wdt_expire_i), .brownout_i(brownout_i),
  .sys_rst_n_o(sys_rst_n_o), .cause_o(cause_o), .fl_oe_o(fl_oe_o),
  .fl_wp_o(fl_wp_o), .fl_ce_o(fl_ce_o));

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 6, PW = 8, FW = 8;

  logic clk = 1'b0;
  logic arst_n, ext_rst_n_i, wdt_expire_i, brownout_i, clr_we_i;
  logic [2:0] clr_data_i, cause_o;
  logic sys_rst_n_o;
  logic [NP*PW-1:0] port_do_i, port_oe_i, port_do_o, port_oe_o;
  logic [FW-1:0] fl_do_i, fl_oe_i, fl_do_o, fl_oe_o;
  logic fl_wp_i, fl_ce_i, fl_wp_o, fl_ce_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_supervisor u_dut (
    .clk(clk), .arst_n(arst_n), .ext_rst_n_i(ext_rst_n_i), .wdt_expire_i(wdt_expire_i),
    .brownout_i(brownout_i), .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
    .cause_o(cause_o), .sys_rst_n_o(sys_rst_n_o),
    .port_do_i(port_do_i), .port_oe_i(port_oe_i), .port_do_o(port_do_o), .port_oe_o(port_oe_o),
    .fl_do_i(fl_do_i), .fl_oe_i(fl_oe_i), .fl_wp_i(fl_wp_i), .fl_ce_i(fl_ce_i),
    .fl_do_o(fl_do_o), .fl_oe_o(fl_oe_o), .fl_wp_o(fl_wp_o), .fl_ce_o(fl_ce_o));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // counts falling edges until the system reset is high; 0 if not within limit
  task automatic count_release(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (sys_rst_n_o && n == 0) n = i;
    end
  endtask

  task automatic settle();
    int n;
    count_release(40, n);
    clr_we_i = 1'b1; clr_data_i = 3'b111;
    @(negedge clk);
    clr_we_i = 1'b0; clr_data_i = 3'b000;
  endtask

  task automatic check_pads_forced(input string req);
    logic [NP*PW-1:0] exp_v;
    exp_v = {{(NP-1)*PW{1'b1}}, {PW{1'b0}}};
    chk(port_do_o == exp_v, req, port_do_o, exp_v);
    chk(port_oe_o == exp_v, req, port_oe_o, exp_v);
    chk(fl_oe_o == '0 && fl_do_o == '0, req, {fl_oe_o, fl_do_o}, 0);
    chk(fl_wp_o == 1'b0 && fl_ce_o == 1'b1, req, {fl_wp_o, fl_ce_o}, 2'b01);
  endtask

  task automatic check_pads_pass(input string req);
    chk(port_do_o == port_do_i && port_oe_o == port_oe_i, req, port_do_o, port_do_i);
    chk(fl_do_o == fl_do_i && fl_oe_o == fl_oe_i && fl_wp_o == fl_wp_i && fl_ce_o == fl_ce_i,
        req, {fl_do_o, fl_oe_o, fl_wp_o, fl_ce_o}, {fl_do_i, fl_oe_i, fl_wp_i, fl_ce_i});
  endtask

  task automatic t_power_on();
    int n;
    arst_n = 1'b0;
    #(CLK_PERIOD*3 + 2);
    chk(sys_rst_n_o == 1'b0, "R9 reset held", sys_rst_n_o, 0);
    chk(cause_o == 3'b000, "R9 cause clear", cause_o, 0);
    check_pads_forced("R8 pads forced at power-on");
    @(negedge clk);
    arst_n = 1'b1;
    count_release(20, n);
    chk(n == 16, "R9 power-on release edge", n, 16);
    check_pads_pass("R8 pads pass through");
  endtask

  task automatic t_ext_glitch();
    logic seen_low;
    seen_low = 1'b0;
    ext_rst_n_i = 1'b0;
    repeat (3) @(negedge clk);
    ext_rst_n_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!sys_rst_n_o) seen_low = 1'b1;
    end
    chk(!seen_low, "R1 3-clock glitch ignored", seen_low, 0);
    chk(cause_o == 3'b000, "R1 glitch leaves cause", cause_o, 0);
  endtask

  task automatic t_ext_min();
    logic seen_low;
    seen_low = 1'b0;
    ext_rst_n_i = 1'b0;
    repeat (4) @(negedge clk);
    ext_rst_n_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!sys_rst_n_o) seen_low = 1'b1;
    end
    chk(seen_low, "R1 4-clock pulse resets", seen_low, 1);
    chk(cause_o == 3'b010, "R4 pin cause", cause_o, 3'b010);
    settle();
  endtask

  task automatic t_ext_release();
    int n;
    ext_rst_n_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(sys_rst_n_o == 1'b0, "R1 long pin low resets", sys_rst_n_o, 0);
    check_pads_forced("R8 pads forced on pin reset");
    ext_rst_n_i = 1'b1;
    count_release(25, n);
    chk(n == 19, "R3 release after pin", n, 19);
    chk(cause_o == 3'b010, "R7 cause survives reset", cause_o, 3'b010);
    settle();
  endtask

  task automatic t_wdt_and_clear();
    int n;
    wdt_expire_i = 1'b1;
    @(negedge clk);
    wdt_expire_i = 1'b0;
    chk(sys_rst_n_o == 1'b0, "R2 watchdog resets", sys_rst_n_o, 0);
    chk(cause_o == 3'b100, "R4 watchdog cause", cause_o, 3'b100);
    count_release(20, n);
    chk(n == 16, "R3 release after watchdog", n, 16);
    chk(cause_o == 3'b100, "R7 cause kept after release", cause_o, 3'b100);
    clr_we_i = 1'b1; clr_data_i = 3'b011;
    @(negedge clk);
    clr_we_i = 1'b0;
    chk(cause_o == 3'b100, "R7 zero mask bits keep cause", cause_o, 3'b100);
    clr_we_i = 1'b1; clr_data_i = 3'b100;
    @(negedge clk);
    clr_we_i = 1'b0; clr_data_i = 3'b000;
    chk(cause_o == 3'b000, "R7 write-one clears", cause_o, 0);
    settle();
  endtask

  task automatic t_set_over_clear();
    wdt_expire_i = 1'b1;
    @(negedge clk);
    wdt_expire_i = 1'b0;
    repeat (18) @(negedge clk);
    chk(cause_o == 3'b100, "R7 precondition", cause_o, 3'b100);
    wdt_expire_i = 1'b1; clr_we_i = 1'b1; clr_data_i = 3'b100;
    @(negedge clk);
    wdt_expire_i = 1'b0; clr_we_i = 1'b0; clr_data_i = 3'b000;
    chk(cause_o == 3'b100, "R7 set wins over clear", cause_o, 3'b100);
    settle();
  endtask

  task automatic t_pf_overrides();
    ext_rst_n_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(cause_o == 3'b010, "R4 pin cause before power-fail", cause_o, 3'b010);
    brownout_i = 1'b1;
    #1;
    chk(sys_rst_n_o == 1'b0, "R2 power-fail immediate", sys_rst_n_o, 0);
    repeat (4) @(negedge clk);
    chk(cause_o == 3'b001, "R6 power-fail clears others", cause_o, 3'b001);
    wdt_expire_i = 1'b1;
    @(negedge clk);
    wdt_expire_i = 1'b0;
    chk(cause_o == 3'b101, "R5 watchdog joins ongoing reset", cause_o, 3'b101);
    ext_rst_n_i = 1'b1;
    brownout_i = 1'b0;
    settle();
  endtask

  task automatic t_pf_alone();
    int n;
    @(negedge clk);
    brownout_i = 1'b1;
    #1;
    chk(sys_rst_n_o == 1'b0, "R2 power-fail alone", sys_rst_n_o, 0);
    repeat (4) @(negedge clk);
    chk(cause_o == 3'b001, "R4 power-fail cause", cause_o, 3'b001);
    brownout_i = 1'b0;
    count_release(25, n);
    chk(n != 0, "R3 release after power-fail", n, 1);
    settle();
  endtask

  task automatic t_simultaneous();
    brownout_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wdt_expire_i = 1'b1;
    @(negedge clk);
    wdt_expire_i = 1'b0;
    chk(cause_o == 3'b101, "R5 same-cycle sources", cause_o, 3'b101);
    brownout_i = 1'b0;
    settle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected finish");
    summary();
  end

  initial begin
    arst_n = 1'b0; ext_rst_n_i = 1'b1; wdt_expire_i = 1'b0; brownout_i = 1'b0;
    clr_we_i = 1'b0; clr_data_i = 3'b000;
    port_do_i = 48'hA5C3_3C5A_9612; port_oe_i = 48'h0F0F_F0F0_55AA;
    fl_do_i = 8'h3C; fl_oe_i = 8'hFF; fl_wp_i = 1'b1; fl_ce_i = 1'b0;
    t_power_on();
    t_ext_glitch();
    t_ext_min();
    t_ext_release();
    t_wdt_and_clear();
    t_set_over_clear();
    t_pf_overrides();
    t_pf_alone();
    t_simultaneous();
    summary();
  end
endmodule